// File: doc/BRIEF.md
# Multi-Function Message Mailbox Core

This block carries fixed-size messages between a small group of host functions: a few parent functions, each owning a group of child (virtual) functions. Every function has an outbox that it fills word by word. It then posts the message with a send command. The receiver reads the message in place through its inbox window and frees the sender with a receive-done command. One shared register port carries every access. Each access is tagged with the ID of the function issuing it, and one access is handled per cycle.

Function IDs are numbered as follows. Parents take IDs `0 .. N_PF-1`. Child `k` of parent `p` has ID `N_PF + p*VF_PER_PF + k`. A child always sends to its own parent. A parent sends to the function held in its target register, and it reads its inbox from that same function. Each receiver keeps a first-in first-out queue of the functions that have messages waiting for it. The head of that queue is reported as the current source.

Each function's outbox is controlled by a two-state machine.
- States: `OB_IDLE` (outbox free) and `OB_POSTED` (message waiting for acceptance).
- Transition *post*: from `OB_IDLE` to `OB_POSTED`, taken on a legal send.
- Transition *accept*: from `OB_POSTED` to `OB_IDLE`, taken when the receiver issues receive-done with this function at the head of its queue.
- Transition *reject*: from `OB_POSTED` back to `OB_POSTED`, taken on a repeated send; it sets the sticky error bit.
- An illegal send leaves `OB_IDLE` unchanged.

Top module: `mbx_core`

## Requirements
- R1: After reset, every function reads a status of 0, meaning not busy, nothing pending, no error and current source 0. Read data is 0 until the first read. A reset taken mid-run clears all posted messages, pending queues and error bits.
- R2: A write to address `0x00+i` stores word `i` of the issuing function's outbox. A read of the same address returns that word on `acc_rdata` one cycle after the read.
- R3: Writing 0x1 to the command word (address 0x40) sends a message. The destination is the parent for a child, and the target-register value for a parent. A legal send sets the sender's busy flag (status bit 0) and the destination's pending flag (status bit 1).
- R4: The target register is at address 0x41 and is readable. A read of inbox word `0x20+i` returns outbox word `i` of a chosen sender. For a parent, that sender is the function in its target register. For a child, it is its parent.
- R5: Status bits [15:8] hold the ID of the oldest pending sender. Senders are served in arrival order.
- R6: Writing 0x2 to the command word signals receive-done. It removes the oldest pending entry and clears that sender's busy flag. The pending flag stays set while further entries remain.
- R7: A send issued while the sender is busy is ignored, and the receiver's queue is unchanged. It sets the sender's error bit (status bit 2), which stays set until reset.
- R8: Only three kinds of send are legal: a child to its parent, a parent to a child of its own group, and a parent to a different parent. Any other send, including one to itself or to an unused ID, changes no flag at all.
- R9: Outbox writes while the issuing function is busy are ignored.
- R10: A receive-done with an empty queue has no effect on any status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Register access valid this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_fn | input | FN_W (4) | ID of the function making the access |
| acc_addr | input | ADDR_W (7) | Word address: outbox, inbox, command, target |
| acc_wdata | input | DATA_W (32) | Write data |
| acc_rdata | output | DATA_W (32) | Read data, registered, valid one cycle after a read |

## Verification
A bad outbox state shows in the sender's status bit 0 on the very next status read. Two faults are visible the same way: a message that is never freed, and a second message that slips in while one is outstanding. A corrupted pending queue appears as a wrong current-source field or a wrong pending bit at the receiver. A fault in indirect addressing returns another function's outbox word one cycle after the inbox read. Illegal-path and double-send cases are each followed at once by status reads of both the sender and the would-be receiver.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic {
        OB_IDLE   = 1'b0,
        OB_POSTED = 1'b1
    } ob_state_e;

    localparam logic [1:0] RG_OBOX = 2'd0;
    localparam logic [1:0] RG_IBOX = 2'd1;
    localparam logic [1:0] RG_CTRL = 2'd2;

    localparam int W_CMD = 0;
    localparam int W_TGT = 1;

    localparam int CMD_SEND = 1;
    localparam int CMD_DONE = 2;

    localparam int ST_BUSY = 0;
    localparam int ST_PEND = 1;
    localparam int ST_ERR  = 2;
    localparam int ST_SRC  = 8;
endpackage

// File: rtl/mbx_obox_fsm.sv
module mbx_obox_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic send_req,
    input  logic send_ok,
    input  logic accept,
    output logic busy,
    output logic err
);
    import mbx_pkg::*;

    ob_state_e st_q, st_nx;

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            OB_IDLE:   if (send_req && send_ok) st_nx = OB_POSTED;
            OB_POSTED: if (accept)              st_nx = OB_IDLE;
            default:                            st_nx = OB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= OB_IDLE;
            err  <= 1'b0;
        end else begin
            st_q <= st_nx;
            if (st_q == OB_POSTED && send_req) err <= 1'b1;
        end
    end

    always_comb begin
        busy = (st_q == OB_POSTED);
    end
endmodule

// File: rtl/mbx_src_queue.sv
module mbx_src_queue #(
    parameter int DEPTH = 10,
    parameter int ID_W  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [ID_W-1:0] push_id,
    input  logic            pop,
    output logic [ID_W-1:0] head,
    output logic            nempty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = PTR_W + 1;

    logic [ID_W-1:0]  mem_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push && (cnt_q < CNT_W'(DEPTH));
    assign do_pop  = pop && (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (do_push) begin
                mem_q[wr_q] <= push_id;
                wr_q        <= bump(wr_q);
            end
            if (do_pop) rd_q <= bump(rd_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign head   = mem_q[rd_q];
    assign nempty = (cnt_q != '0);
endmodule

// File: rtl/mbx_core.sv
module mbx_core #(
    parameter int N_PF      = 2,
    parameter int VF_PER_PF = 4,
    parameter int MSG_BYTES = 128,
    parameter int DATA_W    = 32,
    localparam int N_FN      = N_PF + N_PF * VF_PER_PF,
    localparam int FN_W      = $clog2(N_FN),
    localparam int MSG_WORDS = MSG_BYTES * 8 / DATA_W,
    localparam int WIX_W     = $clog2(MSG_WORDS),
    localparam int ADDR_W    = WIX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [FN_W-1:0]   acc_fn,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata
);
    import mbx_pkg::*;

    function automatic bit is_parent(input int f);
        return f < N_PF;
    endfunction

    function automatic int parent_of(input int f);
        return (f - N_PF) / VF_PER_PF;
    endfunction

    function automatic bit path_ok(input int s, input int d);
        if (s >= N_FN || d >= N_FN || s == d) return 1'b0;
        if (is_parent(s)) return is_parent(d) || (parent_of(d) == s);
        return d == parent_of(s);
    endfunction

    logic [FN_W-1:0]   tgt_q   [N_FN];
    logic [DATA_W-1:0] obox_q  [N_FN*MSG_WORDS];
    logic [FN_W-1:0]   head_id [N_FN];
    logic [FN_W-1:0]   dest_id [N_FN];

    logic [N_FN-1:0] busy_vec, err_vec, accept_vec, push_vec;
    logic [N_FN-1:0] send_req_vec, send_ok_vec, nempty_vec, pop_vec;

    logic [1:0]        region;
    logic [WIX_W-1:0]  widx;
    logic              fn_ok, wr_acc, rd_acc, cmd_send, cmd_done;
    logic              snd_go, done_go;
    logic [FN_W-1:0]   snd_dst, done_src, ib_src;
    logic [DATA_W-1:0] rd_nx;

    assign region   = acc_addr[ADDR_W-1 -: 2];
    assign widx     = acc_addr[WIX_W-1:0];
    assign fn_ok    = int'(acc_fn) < N_FN;
    assign wr_acc   = acc_en && acc_we && fn_ok;
    assign rd_acc   = acc_en && !acc_we && fn_ok;
    assign cmd_send = wr_acc && region == RG_CTRL && widx == WIX_W'(W_CMD)
                      && acc_wdata == DATA_W'(CMD_SEND);
    assign cmd_done = wr_acc && region == RG_CTRL && widx == WIX_W'(W_CMD)
                      && acc_wdata == DATA_W'(CMD_DONE);

    always_comb begin
        snd_go   = 1'b0;
        snd_dst  = '0;
        done_go  = 1'b0;
        done_src = '0;
        if (fn_ok) begin
            snd_go   = cmd_send && !busy_vec[acc_fn] && send_ok_vec[acc_fn];
            snd_dst  = dest_id[acc_fn];
            done_go  = cmd_done && nempty_vec[acc_fn];
            done_src = head_id[acc_fn];
        end
    end

    for (genvar f = 0; f < N_FN; f++) begin : g_fn
        if (f < N_PF) begin : g_par
            assign dest_id[f] = tgt_q[f];
        end else begin : g_vf
            assign dest_id[f] = FN_W'(parent_of(f));
        end

        assign send_ok_vec[f]  = path_ok(f, int'(dest_id[f]));
        assign send_req_vec[f] = cmd_send && acc_fn == FN_W'(f);
        assign accept_vec[f]   = done_go && done_src == FN_W'(f);
        assign push_vec[f]     = snd_go && snd_dst == FN_W'(f);
        assign pop_vec[f]      = done_go && acc_fn == FN_W'(f);

        mbx_obox_fsm u_ob (
            .clk      (clk),
            .rst_n    (rst_n),
            .send_req (send_req_vec[f]),
            .send_ok  (send_ok_vec[f]),
            .accept   (accept_vec[f]),
            .busy     (busy_vec[f]),
            .err      (err_vec[f])
        );

        mbx_src_queue #(.DEPTH(N_FN), .ID_W(FN_W)) u_q (
            .clk     (clk),
            .rst_n   (rst_n),
            .push    (push_vec[f]),
            .push_id (acc_fn),
            .pop     (pop_vec[f]),
            .head    (head_id[f]),
            .nempty  (nempty_vec[f])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_FN; i++) tgt_q[i] <= '0;
        end else if (wr_acc && region == RG_CTRL && widx == WIX_W'(W_TGT)) begin
            tgt_q[acc_fn] <= acc_wdata[FN_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (wr_acc && region == RG_OBOX && !busy_vec[acc_fn]) begin
            obox_q[int'(acc_fn) * MSG_WORDS + int'(widx)] <= acc_wdata;
        end
    end

    always_comb begin
        rd_nx  = '0;
        ib_src = '0;
        if (fn_ok) begin
            ib_src = is_parent(int'(acc_fn)) ? tgt_q[acc_fn]
                                             : FN_W'(parent_of(int'(acc_fn)));
            case (region)
                RG_OBOX: rd_nx = obox_q[int'(acc_fn) * MSG_WORDS + int'(widx)];
                RG_IBOX: if (int'(ib_src) < N_FN)
                             rd_nx = obox_q[int'(ib_src) * MSG_WORDS + int'(widx)];
                RG_CTRL: begin
                    if (widx == WIX_W'(W_CMD)) begin
                        rd_nx[ST_BUSY] = busy_vec[acc_fn];
                        rd_nx[ST_PEND] = nempty_vec[acc_fn];
                        rd_nx[ST_ERR]  = err_vec[acc_fn];
                        if (nempty_vec[acc_fn]) rd_nx[ST_SRC +: FN_W] = head_id[acc_fn];
                    end else if (widx == WIX_W'(W_TGT)) begin
                        rd_nx[FN_W-1:0] = tgt_q[acc_fn];
                    end
                end
                default: rd_nx = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      acc_rdata <= '0;
        else if (rd_acc) acc_rdata <= rd_nx;
    end
endmodule

// File: rtl/mbx_core_chk.sv
module mbx_core_chk #(
    parameter int N_FN = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_FN-1:0] busy_vec,
    input logic [N_FN-1:0] err_vec,
    input logic [N_FN-1:0] accept_vec,
    input logic [N_FN-1:0] push_vec,
    input logic [N_FN-1:0] send_req_vec,
    input logic [N_FN-1:0] send_ok_vec,
    input logic [N_FN-1:0] nempty_vec
);
    p_one_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(push_vec));

    for (genvar f = 0; f < N_FN; f++) begin : g_chk
        p_push_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
            push_vec[f] |=> nempty_vec[f]);
        p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            busy_vec[f] && !accept_vec[f] |=> busy_vec[f]);
        p_accept_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
            accept_vec[f] |=> !busy_vec[f]);
        p_reject_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
            send_req_vec[f] && busy_vec[f] |=> err_vec[f]);
        p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            err_vec[f] |=> err_vec[f]);
        p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
            send_req_vec[f] && !send_ok_vec[f] && !busy_vec[f] |=> !busy_vec[f]);
    end
endmodule

bind mbx_core mbx_core_chk #(.N_FN(N_FN)) u_mbx_chk (.*);

// File: tb/test_mbx_core.sv
module test_mbx_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_we = 1'b0;
    logic [3:0]  acc_fn = '0;
    logic [6:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    mbx_core i_mbx_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (acc_en),
        .acc_we    (acc_we),
        .acc_fn    (acc_fn),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata)
    );

    typedef struct packed {
        logic        we;
        logic [3:0]  fn;
        logic [6:0]  addr;
        logic [31:0] d;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 57;
    // Reads compare against d; writes drive d. IDs: parents 0,1; children 2..5 of 0, 6..9 of 1.
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'd2, 7'h00, 32'hA0A0_0002, 8'd2},  // R2 outbox fill
        '{1'b1, 4'd2, 7'h1F, 32'hA0A0_001F, 8'd2},
        '{1'b0, 4'd2, 7'h00, 32'hA0A0_0002, 8'd2},
        '{1'b0, 4'd2, 7'h1F, 32'hA0A0_001F, 8'd2},
        '{1'b1, 4'd3, 7'h00, 32'h0303_0303, 8'd3},  // R3
        '{1'b1, 4'd2, 7'h40, 32'h0000_0001, 8'd3},
        '{1'b0, 4'd2, 7'h40, 32'h0000_0001, 8'd3},
        '{1'b0, 4'd0, 7'h40, 32'h0000_0202, 8'd3},
        '{1'b1, 4'd3, 7'h40, 32'h0000_0001, 8'd5},  // R5 order
        '{1'b0, 4'd0, 7'h40, 32'h0000_0202, 8'd5},
        '{1'b0, 4'd3, 7'h40, 32'h0000_0001, 8'd3},
        '{1'b1, 4'd0, 7'h41, 32'h0000_0002, 8'd4},  // R4 indirect
        '{1'b0, 4'd0, 7'h41, 32'h0000_0002, 8'd4},
        '{1'b0, 4'd0, 7'h20, 32'hA0A0_0002, 8'd4},
        '{1'b0, 4'd0, 7'h3F, 32'hA0A0_001F, 8'd4},
        '{1'b1, 4'd2, 7'h00, 32'hDEAD_BEEF, 8'd9},  // R9
        '{1'b0, 4'd2, 7'h00, 32'hA0A0_0002, 8'd9},
        '{1'b1, 4'd2, 7'h40, 32'h0000_0001, 8'd7},  // R7
        '{1'b0, 4'd2, 7'h40, 32'h0000_0005, 8'd7},
        '{1'b0, 4'd0, 7'h40, 32'h0000_0202, 8'd7},
        '{1'b1, 4'd0, 7'h40, 32'h0000_0002, 8'd6},  // R6
        '{1'b0, 4'd2, 7'h40, 32'h0000_0004, 8'd6},
        '{1'b0, 4'd0, 7'h40, 32'h0000_0302, 8'd5},
        '{1'b1, 4'd0, 7'h41, 32'h0000_0003, 8'd4},
        '{1'b0, 4'd0, 7'h20, 32'h0303_0303, 8'd4},
        '{1'b1, 4'd0, 7'h40, 32'h0000_0002, 8'd6},
        '{1'b0, 4'd0, 7'h40, 32'h0000_0000, 8'd6},
        '{1'b0, 4'd3, 7'h40, 32'h0000_0000, 8'd6},
        '{1'b1, 4'd0, 7'h40, 32'h0000_0002, 8'd10}, // R10
        '{1'b0, 4'd0, 7'h40, 32'h0000_0000, 8'd10},
        '{1'b0, 4'd3, 7'h40, 32'h0000_0000, 8'd10},
        '{1'b1, 4'd0, 7'h41, 32'h0000_0006, 8'd8},  // R8 foreign child
        '{1'b1, 4'd0, 7'h40, 32'h0000_0001, 8'd8},
        '{1'b0, 4'd0, 7'h40, 32'h0000_0000, 8'd8},
        '{1'b0, 4'd6, 7'h40, 32'h0000_0000, 8'd8},
        '{1'b0, 4'd1, 7'h40, 32'h0000_0000, 8'd8},
        '{1'b1, 4'd0, 7'h41, 32'h0000_0000, 8'd8},  // R8 self
        '{1'b1, 4'd0, 7'h40, 32'h0000_0001, 8'd8},
        '{1'b0, 4'd0, 7'h40, 32'h0000_0000, 8'd8},
        '{1'b1, 4'd1, 7'h05, 32'h1111_0005, 8'd3},  // R3 parent to parent
        '{1'b1, 4'd1, 7'h41, 32'h0000_0000, 8'd3},
        '{1'b1, 4'd1, 7'h40, 32'h0000_0001, 8'd3},
        '{1'b0, 4'd1, 7'h40, 32'h0000_0001, 8'd3},
        '{1'b0, 4'd0, 7'h40, 32'h0000_0102, 8'd3},
        '{1'b1, 4'd0, 7'h41, 32'h0000_0001, 8'd4},
        '{1'b0, 4'd0, 7'h25, 32'h1111_0005, 8'd4},
        '{1'b1, 4'd0, 7'h41, 32'h0000_0004, 8'd3},  // R3 parent to child
        '{1'b1, 4'd0, 7'h01, 32'h0000_4444, 8'd3},
        '{1'b1, 4'd0, 7'h40, 32'h0000_0001, 8'd3},
        '{1'b0, 4'd4, 7'h40, 32'h0000_0002, 8'd3},
        '{1'b0, 4'd4, 7'h21, 32'h0000_4444, 8'd4},
        '{1'b1, 4'd4, 7'h40, 32'h0000_0002, 8'd6},
        '{1'b0, 4'd0, 7'h40, 32'h0000_0102, 8'd6},
        '{1'b0, 4'd4, 7'h40, 32'h0000_0000, 8'd6},
        '{1'b1, 4'd0, 7'h40, 32'h0000_0002, 8'd6},
        '{1'b0, 4'd1, 7'h40, 32'h0000_0000, 8'd6},
        '{1'b0, 4'd0, 7'h40, 32'h0000_0000, 8'd6}
    };

    task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d actual=%08h expected=%08h", req, got, exp);
        end
    endtask

    task automatic acc(input logic we, input logic [3:0] fn, input logic [6:0] a,
                       input logic [31:0] d, output logic [31:0] q);
        @(negedge clk);
        acc_en    = 1'b1;
        acc_we    = we;
        acc_fn    = fn;
        acc_addr  = a;
        acc_wdata = d;
        @(posedge clk);
        @(negedge clk);
        acc_en = 1'b0;
        acc_we = 1'b0;
        q = acc_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL all-R watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] q;
        do_reset();
        check(1, acc_rdata, 32'h0);  // R1 read data after reset
        for (int f = 0; f < 10; f++) begin
            acc(1'b0, 4'(f), 7'h40, 32'h0, q);
            check(1, q, 32'h0);      // R1 status clear
        end

        for (int i = 0; i < NV; i++) begin
            acc(VEC[i].we, VEC[i].fn, VEC[i].addr, VEC[i].d, q);
            if (!VEC[i].we) check(int'(VEC[i].req), q, VEC[i].d);
        end

        // R8: target beyond the last function ID
        acc(1'b1, 4'd0, 7'h41, 32'd12, q);
        acc(1'b1, 4'd0, 7'h40, 32'd1, q);
        acc(1'b0, 4'd0, 7'h40, 32'h0, q);
        check(8, q, 32'h0);

        // R1: reset mid-run clears error, posted and pending state
        acc(1'b1, 4'd5, 7'h40, 32'd1, q);
        acc(1'b0, 4'd0, 7'h40, 32'h0, q);
        check(5, q, 32'h0000_0502);  // R5 child 5 pending at parent 0
        acc(1'b0, 4'd2, 7'h40, 32'h0, q);
        check(7, q, 32'h0000_0004);  // R7 error still sticky
        do_reset();
        acc(1'b0, 4'd0, 7'h40, 32'h0, q);
        check(1, q, 32'h0);
        acc(1'b0, 4'd5, 7'h40, 32'h0, q);
        check(1, q, 32'h0);
        acc(1'b0, 4'd2, 7'h40, 32'h0, q);
        check(1, q, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule